// File: doc/BRIEF.md
# Pre-Trigger Event Capture Buffer

This block sits behind a parallel ADC and keeps a short history of the sample stream in an on-chip ring memory that is written without pause. An event is started by an external trigger strobe or by a threshold detector that watches the same stream. When the event starts, the block saves its configuration and the ring position. It then waits for the samples that follow the trigger. After that it copies the whole window into a free event slot: a set number of samples from before the trigger, the trigger sample itself, and the samples after it. The copy runs from the oldest window sample to the newest.

Event slots are separate from the ring, so sampling and new captures go on while stored events are waiting. A slow consumer drains the stored events one sample at a time through a valid/ready read port. The sample input has no ready. The converter cannot be stalled, so a sample offered with `s_valid` is always taken. On the read side, `m_valid`, `m_data` and `m_last` stay fixed until the consumer accepts the word with `m_ready`. A trigger that finds every slot occupied is discarded and counted.

Top module: `ptc_capture`

## Requirements
- R1: If sample number t causes the trigger, the stored event holds samples t-P through t-P+W-1 in stream order. Here P is the effective pre-trigger length and W is the effective window length. Gaps in the sample stream do not affect which samples are stored.
- R2: `cfg_win` and `cfg_pre` are read only on the trigger sample. The effective window W is `cfg_win` clamped to the range 1 to RING_DEPTH. The effective pre-trigger length P is `cfg_pre` reduced to at most W-1. A change to either input after the trigger has no effect on that event.
- R3: A capture starts when `ext_trig` is high together with `s_valid` while the block is armed.
- R4: While `thr_en` is high, the threshold detector fires on a valid sample that crosses `thr_level`. The previous valid sample is compared with the current one.
  - With `thr_falling`=0 (rising), it fires when prev < level and cur >= level.
  - With `thr_falling`=1 (falling), it fires when prev > level and cur <= level.
  - The first sample after reset never fires.
- R5: The block re-arms only after an event has been committed to its slot. Triggers that arrive while a capture or copy is in progress are ignored. They create no event and do not change `ovf_count`.
- R6: Events are read out in the order they were captured. There are SLOTS slots. A trigger that arrives while every slot is full is dropped, and `ovf_count` increments by one, saturating at its maximum.
- R7: While `m_valid` is high and `m_ready` is low, `m_data` and `m_last` hold their values. `m_last` is high only on the final sample of an event. A slot becomes free once its final sample has been handed to the output.
- R8: After reset, `m_valid` and `m_last` are 0 and `ovf_count` is 0.
- R9: A new event can be captured while earlier events are still waiting in their slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | A sample is present on s_data |
| s_data | input | DATA_W | ADC sample, unsigned |
| ext_trig | input | 1 | External trigger, qualified by s_valid |
| thr_en | input | 1 | Enables the threshold detector |
| thr_level | input | DATA_W | Threshold level |
| thr_falling | input | 1 | 0 selects a rising crossing, 1 selects a falling crossing |
| cfg_pre | input | $clog2(RING_DEPTH+1) | Requested pre-trigger sample count |
| cfg_win | input | $clog2(RING_DEPTH+1) | Requested total window length |
| m_valid | output | 1 | Read port word valid |
| m_ready | input | 1 | Consumer accepts the word |
| m_data | output | DATA_W | Stored event sample |
| m_last | output | 1 | Final sample of the event |
| ovf_count | output | OVF_W | Count of dropped triggers, saturating |

## Verification
The checks assume the consumer never requests a word before the block offers one. They also assume that a dropped trigger is possible only when every slot is occupied, and that no word appears at the output unless some slot holds an event. The stimulus keeps at least RING_DEPTH samples in the ring before the first trigger, so every pre-trigger sample was really written. The threshold enable is held high only over the samples that lead up to the crossing the bench expects, so no stray crossing can start an extra capture.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [1:0] {
    CAP_ARMED = 2'd0,
    CAP_POST  = 2'd1,
    CAP_COPY  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/ptc_trig.sv
module ptc_trig #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              armed,
  input  logic              ext_trig,
  input  logic              thr_en,
  input  logic [DATA_W-1:0] thr_level,
  input  logic              thr_falling,
  output logic              fire
);
  logic [DATA_W-1:0] prev_q;
  logic              have_prev_q;
  logic              up_cross, down_cross, lvl_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (s_valid) begin
      prev_q      <= s_data;
      have_prev_q <= 1'b1;
    end
  end

  always_comb begin
    up_cross   = have_prev_q && (prev_q < thr_level) && (s_data >= thr_level);
    down_cross = have_prev_q && (prev_q > thr_level) && (s_data <= thr_level);
    lvl_hit    = thr_en && (thr_falling ? down_cross : up_cross);
    fire       = armed && s_valid && (ext_trig || lvl_hit);
  end
endmodule

// File: rtl/ptc_ring.sv
module ptc_ring #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [AW-1:0]     wr_ptr,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) wr_ptr <= '0;
    else if (wr_en) wr_ptr <= wr_ptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ptc_store.sv
module ptc_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int SLOTS  = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic [LW-1:0]     commit_len,
  output logic              wr_free,
  output logic [SLOTS-1:0]  full,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last
);
  logic [DATA_W-1:0] mem [SLOTS*DEPTH];
  logic [LW-1:0]     slot_len [SLOTS];
  logic [SW-1:0]     wr_slot, rd_slot;
  logic [AW-1:0]     rd_idx;
  logic              load, final_word;

  function automatic logic [SW-1:0] next_slot(input logic [SW-1:0] s);
    return (s == SW'(SLOTS - 1)) ? '0 : s + SW'(1);
  endfunction

  assign wr_free    = !full[wr_slot];
  assign load       = (!m_valid || m_ready) && full[rd_slot];
  assign final_word = (LW'(rd_idx) + LW'(1)) == slot_len[rd_slot];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_slot, wr_idx}] <= wr_data;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full[s]     <= 1'b0;
        slot_len[s] <= '0;
      end else begin
        if (commit && wr_slot == SW'(s)) begin
          full[s]     <= 1'b1;
          slot_len[s] <= commit_len;
        end
        if (load && final_word && rd_slot == SW'(s)) full[s] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_slot <= '0;
      rd_slot <= '0;
      rd_idx  <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_last  <= 1'b0;
    end else begin
      if (commit) wr_slot <= next_slot(wr_slot);
      if (load) begin
        m_valid <= 1'b1;
        m_data  <= mem[{rd_slot, rd_idx}];
        m_last  <= final_word;
        if (final_word) begin
          rd_idx  <= '0;
          rd_slot <= next_slot(rd_slot);
        end else begin
          rd_idx <= rd_idx + AW'(1);
        end
      end else if (m_ready) begin
        m_valid <= 1'b0;
        m_last  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ptc_capture.sv
module ptc_capture
  import ptc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int RING_DEPTH = 64,
  parameter int SLOTS      = 2,
  parameter int OVF_W      = 8,
  localparam int AW        = $clog2(RING_DEPTH),
  localparam int LW        = $clog2(RING_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              ext_trig,
  input  logic              thr_en,
  input  logic [DATA_W-1:0] thr_level,
  input  logic              thr_falling,
  input  logic [LW-1:0]     cfg_pre,
  input  logic [LW-1:0]     cfg_win,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic [OVF_W-1:0]  ovf_count
);
  cap_state_e        state;
  logic              fire, accept, drop;
  logic [LW-1:0]     win_c, pre_c, lat_win, post_left;
  logic [AW-1:0]     wr_ptr, start_ptr, copy_idx;
  logic [DATA_W-1:0] ring_q;
  logic              wr_free, copy_en, copy_done;
  logic [SLOTS-1:0]  slot_full;

  ptc_trig #(.DATA_W(DATA_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .armed(state == CAP_ARMED), .ext_trig(ext_trig), .thr_en(thr_en),
    .thr_level(thr_level), .thr_falling(thr_falling), .fire(fire)
  );

  ptc_ring #(.DATA_W(DATA_W), .DEPTH(RING_DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(s_valid), .wr_data(s_data),
    .wr_ptr(wr_ptr), .rd_addr(start_ptr + copy_idx), .rd_data(ring_q)
  );

  ptc_store #(.DATA_W(DATA_W), .DEPTH(RING_DEPTH), .SLOTS(SLOTS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(copy_en), .wr_idx(copy_idx),
    .wr_data(ring_q), .commit(copy_done), .commit_len(lat_win),
    .wr_free(wr_free), .full(slot_full), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
  );

  always_comb begin
    if (cfg_win == '0) win_c = LW'(1);
    else if (cfg_win > LW'(RING_DEPTH)) win_c = LW'(RING_DEPTH);
    else win_c = cfg_win;
    if (cfg_pre >= win_c) pre_c = win_c - LW'(1);
    else pre_c = cfg_pre;
  end

  assign accept    = fire && wr_free;
  assign drop      = fire && !wr_free;
  assign copy_en   = (state == CAP_COPY);
  assign copy_done = copy_en && ((LW'(copy_idx) + LW'(1)) == lat_win);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= CAP_ARMED;
      lat_win   <= LW'(1);
      post_left <= '0;
      start_ptr <= '0;
      copy_idx  <= '0;
      ovf_count <= '0;
    end else begin
      case (state)
        CAP_ARMED: begin
          if (accept) begin
            lat_win   <= win_c;
            start_ptr <= wr_ptr - pre_c[AW-1:0];
            post_left <= win_c - pre_c - LW'(1);
            copy_idx  <= '0;
            state     <= (win_c - pre_c == LW'(1)) ? CAP_COPY : CAP_POST;
          end else if (drop && ovf_count != '1) begin
            ovf_count <= ovf_count + OVF_W'(1);
          end
        end
        CAP_POST: begin
          if (s_valid) begin
            post_left <= post_left - LW'(1);
            if (post_left == LW'(1)) state <= CAP_COPY;
          end
        end
        CAP_COPY: begin
          copy_idx <= copy_idx + AW'(1);
          if (copy_done) state <= CAP_ARMED;
        end
        default: state <= CAP_ARMED;
      endcase
    end
  end
endmodule

// File: rtl/ptc_capture_chk.sv
module ptc_capture_chk #(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 2,
  parameter int OVF_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              m_last,
  input logic [OVF_W-1:0]  ovf_count,
  input logic [SLOTS-1:0]  slot_full
);
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |-> m_valid);

  a_r6_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ovf_count == $past(ovf_count) || ovf_count == $past(ovf_count) + OVF_W'(1)));

  a_r6_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count != $past(ovf_count)) |-> $past(&slot_full));

  a_r8_word_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(|slot_full));
endmodule

bind ptc_capture ptc_capture_chk #(
  .DATA_W(DATA_W), .SLOTS(SLOTS), .OVF_W(OVF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_last(m_last), .ovf_count(ovf_count),
  .slot_full(slot_full)
);

// File: tb/tb_ptc_capture.sv
module tb_ptc_capture;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DEPTH = 64;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, ext_trig = 1'b0, thr_en = 1'b0, thr_falling = 1'b0;
  logic [DW-1:0] s_data = '0, thr_level = '0, m_data;
  logic [LW-1:0] cfg_pre = '0, cfg_win = LW'(1);
  logic m_valid, m_ready = 1'b0, m_last;
  logic [7:0] ovf_count;

  ptc_capture #(.DATA_W(DW), .RING_DEPTH(DEPTH), .SLOTS(2), .OVF_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .ext_trig(ext_trig), .thr_en(thr_en), .thr_level(thr_level),
    .thr_falling(thr_falling), .cfg_pre(cfg_pre), .cfg_win(cfg_win),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_last(m_last), .ovf_count(ovf_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;
  int idx = 0, cyc = 0;
  int trig_a = -1, trig_b = -1, trig_c = -1;
  int en_from = -1, en_until = -1;
  bit gap_on = 0;

  // mode: 0 external, 1 rising threshold, 2 falling threshold
  typedef struct packed {
    int pre; int win; int mode; int thr; int gap; int stall;
    int exp_pre; int exp_win; int req;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{8,  20,  0, 0,    0, 0, 8,  20, 1},
    '{0,  16,  0, 0,    1, 0, 0,  16, 8},
    '{15, 64,  0, 0,    0, 1, 15, 64, 2},
    '{5,  100, 0, 0,    0, 0, 5,  64, 2},
    '{30, 10,  0, 0,    0, 0, 9,  10, 2},
    '{0,  0,   0, 0,    0, 0, 0,  1,  2},
    '{6,  24,  1, 2000, 1, 0, 6,  24, 4},
    '{4,  18,  2, 3000, 0, 1, 4,  18, 4}
  };

  function automatic string req_name(int r);
    case (r)
      1: return "R1 window content";
      2: return "R2 length clamp";
      4: return "R4 threshold crossing";
      8: return "R1 with gaps";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [DW-1:0] val(int n);
    int p = n % 200;
    if (p < 100) return DW'(p * 50);
    return DW'((200 - p) * 50);
  endfunction

  function automatic int find_cross(int from, int thr, bit falling);
    for (int n = from; n < from + 1000; n++) begin
      int pv = int'(val(n - 1));
      int cv = int'(val(n));
      if (!falling && pv < thr && cv >= thr) return n;
      if (falling && pv > thr && cv <= thr) return n;
    end
    return -1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  // sample source: one candidate sample per cycle
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      if (gap_on && (cyc % 3 == 2)) begin
        s_valid = 0; ext_trig = 0; thr_en = 0;
      end else begin
        s_valid = 1;
        s_data = val(idx);
        ext_trig = (idx == trig_a) || (idx == trig_b) || (idx == trig_c);
        thr_en = (idx >= en_from) && (idx <= en_until);
        idx++;
      end
    end
  end

  task automatic read_event(int nt, int pre, int win, bit stall, string tag);
    int got = 0, bad = 0, lbad = 0, cycles = 0, first_act = 0, first_exp = 0;
    while (got < win && cycles < 3000) begin
      bit r;
      @(negedge clk);
      r = stall ? (cycles % 2 == 0) : 1'b1;
      m_ready = r;
      if (m_valid && r) begin
        logic [DW-1:0] e = val(nt - pre + got);
        if (m_data !== e) begin
          if (bad == 0) begin first_act = int'(m_data); first_exp = int'(e); end
          bad++;
        end
        if (m_last !== (got == win - 1)) lbad++;
        got++;
      end
      cycles++;
    end
    @(negedge clk);
    m_ready = 0;
    chk(got == win, {tag, " word count"}, got, win);
    chk(bad == 0, {tag, " data"}, first_act, first_exp);
    chk(lbad == 0, {tag, " R7 last marker"}, lbad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    int ta, tb, tc, ovf0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(m_valid == 0, "R8 m_valid", int'(m_valid), 0);
    chk(m_last == 0, "R8 m_last", int'(m_last), 0);
    chk(ovf_count == 0, "R8 ovf_count", int'(ovf_count), 0);
    repeat (100) @(negedge clk);

    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      int nt;
      cfg_pre = LW'(v.pre); cfg_win = LW'(v.win);
      gap_on = (v.gap != 0);
      thr_level = DW'(v.thr); thr_falling = (v.mode == 2);
      @(negedge clk);
      if (v.mode == 0) begin
        nt = idx + 10; trig_a = nt;
      end else begin
        en_from = idx + 5;
        nt = find_cross(en_from, v.thr, v.mode == 2);
        en_until = nt;
      end
      read_event(nt, v.exp_pre, v.exp_win, v.stall != 0, req_name(v.req));
      trig_a = -1; en_from = -1; en_until = -1; gap_on = 0;
      repeat (10) @(negedge clk);
    end

    // R5: second trigger during post window is ignored
    cfg_pre = LW'(4); cfg_win = LW'(20);
    ovf0 = int'(ovf_count);
    @(negedge clk);
    ta = idx + 10; trig_a = ta; trig_b = ta + 3;
    read_event(ta, 4, 20, 0, "R5 first event");
    trig_a = -1; trig_b = -1;
    repeat (200) @(negedge clk);
    chk(m_valid == 0, "R5 no retrigger event", int'(m_valid), 0);
    chk(int'(ovf_count) == ovf0, "R5 ovf unchanged", int'(ovf_count), ovf0);

    // R6 and R9: fill both slots unread, third trigger dropped
    cfg_pre = LW'(3); cfg_win = LW'(12);
    m_ready = 0;
    ta = idx + 10; trig_a = ta;
    repeat (60) @(negedge clk);
    tb = idx + 10; trig_b = tb;
    repeat (60) @(negedge clk);
    tc = idx + 10; trig_c = tc;
    repeat (60) @(negedge clk);
    trig_a = -1; trig_b = -1; trig_c = -1;
    chk(int'(ovf_count) == ovf0 + 1, "R6 overflow count", int'(ovf_count), ovf0 + 1);
    read_event(ta, 3, 12, 1, "R6 oldest first");
    read_event(tb, 3, 12, 0, "R9 captured while waiting");
    repeat (20) @(negedge clk);
    chk(m_valid == 0, "R6 dropped event absent", int'(m_valid), 0);

    // R2: configuration latched at the trigger sample
    cfg_pre = LW'(2); cfg_win = LW'(10);
    @(negedge clk);
    ta = idx + 5; trig_a = ta;
    while (idx <= ta) @(negedge clk);
    cfg_pre = LW'(20); cfg_win = LW'(40);
    read_event(ta, 2, 10, 0, "R2 latched config");
    trig_a = -1;

    repeat (5) @(negedge clk);
    summary();
  end
endmodule